// File: doc/BRIEF.md
# Eight-Source Interrupt Gating Controller

This block decides when a small 4-bit processor core takes an interrupt. It serves eight sources: two external pins, four timers, an A/D converter and a serial port. Each source has a request flag, which a one-cycle pulse from its peripheral sets. Each source also has an enable bit. The enable bits sit in two 4-bit banks, and the core loads and reads them over its 4-bit accumulator bus using dedicated transfer strobes. A global enable flag gates all sources. A source qualifies when the global flag, its enable bit and its request flag are all 1.

A small sequencer spaces the interrupt from the cycle in which a source first qualifies. The interrupt is taken two machine cycles later, or three when the instruction running in that cycle is multi-cycle. When several sources qualify, a fixed priority picks one and outputs its 3-bit index. Taking an interrupt clears the global enable and the chosen request flag.

The enable bits also govern software polling. A skip-on-request test for a source is valid only while that source's interrupt is disabled. A valid test that finds the flag set reports a skip and consumes the flag.

The clock is the machine cycle.

The sequencer has four states:
- `ST_IDLE` is the rest state.
- `ST_HOLD` is the extra cycle used after a multi-cycle instruction.
- `ST_ARMED` is one cycle before the take.
- `ST_FIRE` is the take cycle.

Its transitions are:
- idle to armed: a source qualifies and `multi_cyc` is 0.
- idle to hold: a source qualifies and `multi_cyc` is 1.
- hold to armed: a source still qualifies.
- armed to fire: a source still qualifies.
- hold, armed or fire to idle: no source qualifies.
- fire to idle: always, after the take.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset, both enable banks read 0000, all request flags are 0, the global enable is 0 and `irq_take` is 0.
- R2: `wr_bank[0]` loads `acc_in` into bank 1 at the next edge. Bank 1 covers source indices 0–3: bit 0 external 0, bit 1 external 1, bit 2 timer 1, bit 3 timer 2. `wr_bank[1]` loads bank 2, which covers indices 4–7: bit 0 timer 3, bit 1 timer 4, bit 2 A/D, bit 3 serial. `rd_bank[0]` puts bank 1 on `acc_out` in the same cycle. `rd_bank[1]` puts bank 2 there. `rd_bank[0]` wins when both are set, and `acc_out` is 0000 when neither is set.
- R3: `wake_clr` clears both banks to 0000 at the next edge and overrides a write in the same cycle.
- R4: A `req_pulse` bit sets its flag at the next edge. The flag holds until a take or a valid skip clears it. A pulse in the same cycle as a clear leaves the flag set. `req_pend` shows the flags.
- R5: A source qualifies only when `int_en`, its enable bit and its flag are all 1. No other combination produces `irq_take`.
- R6: If a source first qualifies in cycle C with `multi_cyc` = 0, `irq_take` is 1 in cycle C+2.
- R7: If `multi_cyc` = 1 in cycle C, `irq_take` is 1 in cycle C+3 instead. `multi_cyc` is ignored while a sequence is under way.
- R8: If no source qualifies in any later cycle up to the take cycle, no take occurs and the sequencer returns to idle.
- R9: With several qualifying sources, `irq_idx` gives the lowest qualifying index (0 = external 0 is highest priority, 7 = serial is lowest).
- R10: A take clears `int_en` and the flag at `irq_idx` at the next edge, even if `gie_set` is 1 in that cycle.
- R11: `skip_ok` is 1 in the same cycle when `skip_req` is 1, the flag at `skip_sel` is 1 and that source's enable bit is 0. A valid skip clears that flag at the next edge. With the enable bit 1, `skip_ok` is 0 and the flag is kept.
- R12: `gie_set` sets `int_en` at the next edge. `gie_clr` clears it and wins over `gie_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_clr | input | 1 | Return from RAM back-up: clear both enable banks |
| acc_in | input | 4 | Accumulator value for bank writes |
| wr_bank | input | 2 | Write strobes; bit 0 bank 1, bit 1 bank 2 |
| rd_bank | input | 2 | Read strobes; bit 0 bank 1, bit 1 bank 2 |
| acc_out | output | 4 | Bank contents for the accumulator |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| req_pulse | input | 8 | One-cycle request pulses, indexed by source |
| multi_cyc | input | 1 | Current instruction is multi-cycle |
| skip_req | input | 1 | Skip-on-request test is executing |
| skip_sel | input | 3 | Source index tested |
| skip_ok | output | 1 | Valid test found the flag set; skip |
| req_pend | output | 8 | Request flags |
| int_en | output | 1 | Global enable flag |
| irq_take | output | 1 | Interrupt taken this cycle |
| irq_idx | output | 3 | Index of the taken source |

## Verification
The bench builds the block with its defaults: two banks of four bits, which gives eight sources and a 3-bit index. These are the only sizes that match the accumulator and the source list. With eight sources, random request pulses, enable writes and global-enable toggles regularly produce multi-source races. That makes the priority choice, flag clears racing new pulses, and sequences aborted midway all reachable. Directed runs fix both latencies, the abort, the wake clear and the skip validity on an enabled and a disabled source.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_ARMED = 2'd2,
        ST_FIRE  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
    parameter int BANK_W  = 4,
    parameter int N_BANKS = 2,
    localparam int NSRC   = BANK_W * N_BANKS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wake_clr,
    input  logic [BANK_W-1:0]  acc_in,
    input  logic [N_BANKS-1:0] wr_bank,
    input  logic [N_BANKS-1:0] rd_bank,
    output logic [BANK_W-1:0]  acc_out,
    output logic [NSRC-1:0]    en_vec
);
    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] bank_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          bank_q <= '0;
            else if (wake_clr)   bank_q <= '0;
            else if (wr_bank[b]) bank_q <= acc_in;
        end
        assign en_vec[b*BANK_W +: BANK_W] = bank_q;

        p_bank_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_bank[b] && !wake_clr) |=> (bank_q == $past(acc_in)));
    end

    // lowest-numbered read strobe drives the bus
    always_comb begin
        acc_out = '0;
        for (int b = N_BANKS - 1; b >= 0; b--) begin
            if (rd_bank[b]) acc_out = en_vec[b*BANK_W +: BANK_W];
        end
    end

    p_wake_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_clr |=> (en_vec == '0));
endmodule

// File: rtl/irq_req_flags.sv
module irq_req_flags #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_pulse,
    input  logic [NSRC-1:0] take_clr,
    input  logic [NSRC-1:0] skip_clr,
    output logic [NSRC-1:0] flags
);
    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         flags[i] <= 1'b0;
            else if (req_pulse[i])              flags[i] <= 1'b1;
            else if (take_clr[i] || skip_clr[i]) flags[i] <= 1'b0;
        end

        p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !take_clr[i] && !skip_clr[i]) |=> flags[i]);
        p_pulse_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            req_pulse[i] |=> flags[i]);
        p_skip_consume_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (skip_clr[i] && !req_pulse[i]) |=> !flags[i]);
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NSRC  = 8,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]  cand,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |cand;
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_qual,
    input  logic multi_cyc,
    input  logic gie_set,
    input  logic gie_clr,
    output logic gie,
    output logic irq_take
);
    seq_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_qual) state_d = multi_cyc ? ST_HOLD : ST_ARMED;
            end
            ST_HOLD:  state_d = any_qual ? ST_ARMED : ST_IDLE;
            ST_ARMED: state_d = any_qual ? ST_FIRE  : ST_IDLE;
            ST_FIRE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_take = 1'b0;
        unique case (state_q)
            ST_FIRE: irq_take = any_qual;
            default: irq_take = 1'b0;
        endcase
    end

    // global enable: take and clear dominate set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    gie <= 1'b0;
        else if (irq_take || gie_clr)  gie <= 1'b0;
        else if (gie_set)              gie <= 1'b1;
    end

    p_take_clears_gie_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !gie);
    p_take_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> ($past(any_qual) && $past(any_qual, 2)));
    p_take_needs_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> gie);
    p_gie_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_set && !gie_clr && !irq_take) |=> gie);
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl #(
    parameter int BANK_W  = 4,
    parameter int N_BANKS = 2,
    localparam int NSRC   = BANK_W * N_BANKS,
    localparam int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wake_clr,
    input  logic [BANK_W-1:0]  acc_in,
    input  logic [N_BANKS-1:0] wr_bank,
    input  logic [N_BANKS-1:0] rd_bank,
    output logic [BANK_W-1:0]  acc_out,
    input  logic               gie_set,
    input  logic               gie_clr,
    input  logic [NSRC-1:0]    req_pulse,
    input  logic               multi_cyc,
    input  logic               skip_req,
    input  logic [IDX_W-1:0]   skip_sel,
    output logic               skip_ok,
    output logic [NSRC-1:0]    req_pend,
    output logic               int_en,
    output logic               irq_take,
    output logic [IDX_W-1:0]   irq_idx
);
    logic [NSRC-1:0] en_vec, qual, take_clr, skip_clr;
    logic            any_qual;

    irq_en_bank #(.BANK_W(BANK_W), .N_BANKS(N_BANKS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wake_clr(wake_clr), .acc_in(acc_in),
        .wr_bank(wr_bank), .rd_bank(rd_bank), .acc_out(acc_out), .en_vec(en_vec)
    );

    irq_req_flags #(.NSRC(NSRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse),
        .take_clr(take_clr), .skip_clr(skip_clr), .flags(req_pend)
    );

    assign qual = req_pend & en_vec & {NSRC{int_en}};

    irq_prio_pick #(.NSRC(NSRC)) u_pick (
        .cand(qual), .any(any_qual), .idx(irq_idx)
    );

    irq_seq_fsm u_seq (
        .clk(clk), .rst_n(rst_n), .any_qual(any_qual), .multi_cyc(multi_cyc),
        .gie_set(gie_set), .gie_clr(gie_clr), .gie(int_en), .irq_take(irq_take)
    );

    // polling test is only valid while the source's interrupt is disabled
    always_comb begin
        skip_ok  = 1'b0;
        skip_clr = '0;
        take_clr = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (skip_req && skip_sel == IDX_W'(i) && req_pend[i] && !en_vec[i]) begin
                skip_ok     = 1'b1;
                skip_clr[i] = 1'b1;
            end
            if (irq_take && irq_idx == IDX_W'(i)) take_clr[i] = 1'b1;
        end
    end

    p_take_qualified_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (req_pend[irq_idx] && en_vec[irq_idx] && int_en));
    p_take_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> ((req_pend & en_vec & ((NSRC'(1) << irq_idx) - NSRC'(1))) == '0));
    p_take_clears_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !req_pulse[irq_idx]) |=> !req_pend[$past(irq_idx)]);
    p_skip_disabled_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        skip_ok |-> !en_vec[skip_sel]);
endmodule

// File: tb/irq_gate_ctrl_tb.sv
module irq_gate_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wake_clr;
    logic [3:0] acc_in;
    logic [1:0] wr_bank, rd_bank;
    logic [3:0] acc_out;
    logic       gie_set, gie_clr, multi_cyc, skip_req;
    logic [7:0] req_pulse;
    logic [2:0] skip_sel;
    logic       skip_ok, int_en, irq_take;
    logic [7:0] req_pend;
    logic [2:0] irq_idx;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    // reference state
    logic [7:0] m_en, m_flag;
    logic       m_gie;
    int         m_wait;
    int         takes = 0;
    int         skips = 0;

    always #4 clk = ~clk;

    irq_gate_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wake_clr(wake_clr), .acc_in(acc_in),
        .wr_bank(wr_bank), .rd_bank(rd_bank), .acc_out(acc_out),
        .gie_set(gie_set), .gie_clr(gie_clr), .req_pulse(req_pulse),
        .multi_cyc(multi_cyc), .skip_req(skip_req), .skip_sel(skip_sel),
        .skip_ok(skip_ok), .req_pend(req_pend), .int_en(int_en),
        .irq_take(irq_take), .irq_idx(irq_idx)
    );

    function automatic logic [2:0] f_first(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return 3'(i);
        return 3'd0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic quiet();
        wake_clr = 0; acc_in = 0; wr_bank = 0; rd_bank = 0; gie_set = 0; gie_clr = 0;
        req_pulse = 0; multi_cyc = 0; skip_req = 0; skip_sel = 0;
    endtask

    // compare outputs, then advance the reference model across one edge
    task automatic step();
        logic [7:0] q, n_flag, n_en;
        logic       anyq, e_take, e_skip, n_gie;
        logic [3:0] e_acc;
        int         n_wait;
        #1;
        q      = m_flag & m_en & {8{m_gie}};
        anyq   = |q;
        e_take = (m_wait == 1) && anyq;
        e_acc  = rd_bank[0] ? m_en[3:0] : (rd_bank[1] ? m_en[7:4] : 4'd0);
        e_skip = skip_req && m_flag[skip_sel] && !m_en[skip_sel];
        chk("R6 R7 R8 R5 irq_take", int'(irq_take), int'(e_take));
        if (e_take) chk("R9 irq_idx", int'(irq_idx), int'(f_first(q)));
        chk("R2 R3 acc_out", int'(acc_out), int'(e_acc));
        chk("R11 skip_ok", int'(skip_ok), int'(e_skip));
        chk("R4 R10 R11 req_pend", int'(req_pend), int'(m_flag));
        chk("R12 R10 int_en", int'(int_en), int'(m_gie));
        if (e_take) takes++;
        if (e_skip) skips++;
        n_en = m_en;
        if (wake_clr) n_en = 8'h00;
        else begin
            if (wr_bank[0]) n_en[3:0] = acc_in;
            if (wr_bank[1]) n_en[7:4] = acc_in;
        end
        n_flag = m_flag;
        if (e_take) n_flag[f_first(q)] = 1'b0;
        if (e_skip) n_flag[skip_sel] = 1'b0;
        n_flag = n_flag | req_pulse;
        n_gie = (e_take || gie_clr) ? 1'b0 : (gie_set ? 1'b1 : m_gie);
        if (m_wait == 0) n_wait = anyq ? (multi_cyc ? 3 : 2) : 0;
        else             n_wait = anyq ? m_wait - 1 : 0;
        @(posedge clk);
        m_en = n_en; m_flag = n_flag; m_gie = n_gie; m_wait = n_wait;
        @(negedge clk);
        quiet();
    endtask

    task automatic do_reset();
        quiet();
        rst_n = 0;
        m_en = 0; m_flag = 0; m_gie = 0; m_wait = 0;
        @(negedge clk);
        rd_bank = 2'b01;
        #1;
        chk("R1 bank1", int'(acc_out), 0);
        chk("R1 flags", int'(req_pend), 0);
        chk("R1 int_en", int'(int_en), 0);
        chk("R1 irq_take", int'(irq_take), 0);
        @(negedge clk);
        rst_n = 1;
        quiet();
    endtask

    // latency from first qualifying cycle to take
    task automatic latency(input bit multi, input int exp, input string tag);
        int n;
        acc_in = 4'b0100; wr_bank = 2'b01; gie_set = 1; step();   // timer 1 enabled
        req_pulse = 8'h04; step();                                // flag set at this edge
        multi_cyc = multi;                                        // C: conditions first hold
        n = 0;
        while (!irq_take && n < 6) begin
            step();
            n++;
            #1;
        end
        chk(tag, n, exp);
        chk({tag, " idx"}, int'(irq_idx), 2);
        step();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C));
        do_reset();

        // R2: write both banks, read each and both
        acc_in = 4'hA; wr_bank = 2'b01; step();
        acc_in = 4'h5; wr_bank = 2'b10; step();
        rd_bank = 2'b01; #1; chk("R2 bank1 read", int'(acc_out), 4'hA); step();
        rd_bank = 2'b10; #1; chk("R2 bank2 read", int'(acc_out), 4'h5); step();
        rd_bank = 2'b11; #1; chk("R2 both read", int'(acc_out), 4'hA); step();

        // R3: wake clear beats write
        wake_clr = 1; acc_in = 4'hF; wr_bank = 2'b11; step();
        rd_bank = 2'b01; #1; chk("R3 bank1 cleared", int'(acc_out), 0); step();
        rd_bank = 2'b10; #1; chk("R3 bank2 cleared", int'(acc_out), 0); step();

        // R11: skip valid with enable 0, invalid with enable 1
        req_pulse = 8'h80; step();
        skip_req = 1; skip_sel = 3'd7; #1; chk("R11 skip valid", int'(skip_ok), 1); step();
        #1; chk("R11 flag consumed", int'(req_pend[7]), 0);
        req_pulse = 8'h80; acc_in = 4'h8; wr_bank = 2'b10; step();
        skip_req = 1; skip_sel = 3'd7; #1; chk("R11 skip invalid when enabled", int'(skip_ok), 0); step();
        #1; chk("R11 flag kept", int'(req_pend[7]), 1);
        wr_bank = 2'b10; acc_in = 0; step();
        skip_req = 1; skip_sel = 3'd7; step();

        // R6 / R7 latency
        latency(1'b0, 2, "R6 two-cycle take");
        latency(1'b1, 3, "R7 three-cycle take");
        #1; chk("R10 gie cleared after take", int'(int_en), 0);

        // R8: qualification withdrawn during sequence
        gie_set = 1; req_pulse = 8'h01; acc_in = 4'h1; wr_bank = 2'b01; step();
        step();                      // C
        gie_clr = 1; step();         // armed, drop global enable
        #1; chk("R8 aborted", int'(irq_take), 0); step();
        skip_req = 0; wr_bank = 2'b01; acc_in = 0; step();
        skip_req = 1; skip_sel = 0; step();

        // R9: simultaneous sources; R10: take overrides gie_set
        acc_in = 4'hF; wr_bank = 2'b01; step();
        acc_in = 4'hF; wr_bank = 2'b10; step();
        req_pulse = 8'b1011_0100; gie_set = 1; step();
        step(); step();
        #1; chk("R9 take", int'(irq_take), 1); chk("R9 lowest index", int'(irq_idx), 2);
        gie_set = 1; step();
        #1; chk("R10 take beats set", int'(int_en), 0);
        chk("R10 flag cleared", int'(req_pend), 8'b1011_0000);
        gie_set = 1; gie_clr = 1; step();
        #1; chk("R12 clear wins", int'(int_en), 0);
        gie_set = 1; step();
        #1; chk("R12 set", int'(int_en), 1);

        // constrained random
        for (int k = 0; k < 6000; k++) begin
            req_pulse = 0;
            for (int b = 0; b < 8; b++) req_pulse[b] = ($urandom % 10) == 0;
            multi_cyc = ($urandom % 3) == 0;
            gie_set   = ($urandom % 5) == 0;
            gie_clr   = ($urandom % 25) == 0;
            if (($urandom % 8) == 0) begin
                wr_bank = 2'($urandom);
                acc_in  = 4'($urandom);
            end
            rd_bank   = 2'($urandom);
            skip_req  = ($urandom % 4) == 0;
            skip_sel  = 3'($urandom);
            wake_clr  = ($urandom % 150) == 0;
            step();
        end
        chk("R6 random takes seen", int'(takes > 20), 1);
        chk("R11 random skips seen", int'(skips > 20), 1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule